// File: doc/BRIEF.md
# Keyed Flash Erase and Program Sequencer

This block controls a byte-wide flash array, built into the block as a behavioural model and split into equal pages. A host drives it through a small register bus. Three registers decide what happens: a control register holds a write-enable bit for programming and an arm bit for mass erase, a page register holds the page to erase, and a key register starts the work. An erase runs only when the key byte matches the setup step that came before it. Mass erase needs the arm bit, the key 0xAA and an asserted debug-enable input. Page erase needs a page-register write followed by the key 0x55. Any other key byte, or a key that was not set up, cancels the pending setup.

A separate data-store port writes bytes. When the program-write-enable bit is set, a store programs the flash, and because programming can only clear bits it keeps the AND of the old and new byte. When the bit is clear, stores go to a small data RAM. One registered read port returns a byte from either memory. While an erase runs, a busy flag stays high for a fixed number of cycles. During that time the erase walks its range writing 0xFF, and register writes and flash programming are dropped.

Top module: `flash_seq_top`

## Requirements
- R1: In the cycle after reset, `busy`, `prog_en` and `mass_arm` read 0, and every flash byte reads 0xFF.
- R2: Writing bus address 0 with bit1 set arms mass erase. A following write of 0xAA to bus address 2 while `dbg_en` is 1 starts a mass erase. When it finishes, every flash byte reads 0xFF and the data RAM is unchanged.
- R3: A 0xAA key while `dbg_en` is 0 starts no erase, changes no flash byte and clears `mass_arm`.
- R4: A write to bus address 1 takes the page number from data bits [PAGE_W:1] (PAGE_W = log2 of the page count; higher bits are ignored). A following 0x55 key sets every byte of that page to 0xFF and leaves bytes outside the page unchanged.
- R5: Any key write clears `mass_arm` and the page setup. A key value other than the expected one, or a key with no setup before it, starts no erase, so a later 0x55 with no new page write does nothing.
- R6: A store with `prog_en` = 1 leaves the flash byte at the bitwise AND of its old value and the store data.
- R7: A store with `prog_en` = 0 writes the data RAM at the low address bits and leaves flash unchanged. `rd_data` returns, one cycle after `rd_addr`/`rd_src` are presented, the flash byte (`rd_src` = 0) or the RAM byte (`rd_src` = 1).
- R8: An accepted erase key raises `busy` in the next cycle, and `busy` stays high for exactly ERASE_CYC cycles.
- R9: While `busy` is high, bus register writes and flash programming stores have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_en | input | 1 | Debug enable; mass erase is allowed only while high |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 page, 2 key |
| bus_wdata | input | 8 | Register write data |
| store_wr | input | 1 | Data-store write strobe |
| store_addr | input | FA_W | Data-store byte address |
| store_wdata | input | 8 | Data-store byte |
| rd_src | input | 1 | Read source: 0 flash, 1 data RAM |
| rd_addr | input | FA_W | Read byte address |
| rd_data | output | 8 | Registered read data |
| busy | output | 1 | Erase in progress |
| prog_en | output | 1 | Current program-write-enable bit |
| mass_arm | output | 1 | Current mass-erase arm bit |

## Verification
The hardest case to reach is a register write or a flash store that arrives inside the busy window. The dropped write must leave no trace, both in the register state and in the flash contents. The stimulus starts a page erase and, in the cycles right after the key, writes the control register to swap both bits and programs a byte outside the page. It then counts how long `busy` stays high and reads back the control bits and that byte once the erase has finished. The mass-erase path without debug enable is driven with the arm bit set just before, so the only thing blocking the erase is the `dbg_en` input.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_PAGE = 2'd1;
  localparam logic [1:0] REG_KEY  = 2'd2;
  localparam logic [7:0] KEY_MASS = 8'hAA;
  localparam logic [7:0] KEY_PAGE = 8'h55;
  localparam logic [7:0] ERASED   = 8'hFF;
endpackage

// File: rtl/fsq_cmd.sv
module fsq_cmd
  import fsq_pkg::*;
#(
  parameter int NUM_PAGES  = 8,
  parameter int PAGE_BYTES = 16,
  parameter int ERASE_CYC  = 160,
  localparam int DEPTH  = NUM_PAGES * PAGE_BYTES,
  localparam int PAGE_W = $clog2(NUM_PAGES),
  localparam int PB_W   = $clog2(PAGE_BYTES),
  localparam int FA_W   = PAGE_W + PB_W,
  localparam int CW     = $clog2(ERASE_CYC + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dbg_en,
  input  logic            bus_wr,
  input  logic [1:0]      bus_addr,
  input  logic [7:0]      bus_wdata,
  output logic            busy_o,
  output logic            pwe_o,
  output logic            arm_o,
  output logic            er_we,
  output logic [FA_W-1:0] er_addr
);
  logic              busy_q, pwe_q, arm_q, pgset_q;
  logic [PAGE_W-1:0] page_q;
  logic [CW-1:0]     cnt_q, len_q;
  logic [FA_W-1:0]   base_q;
  logic              key_wr;

  assign key_wr = bus_wr && !busy_q && (bus_addr == REG_KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      pwe_q   <= 1'b0;
      arm_q   <= 1'b0;
      pgset_q <= 1'b0;
      page_q  <= '0;
      cnt_q   <= '0;
      len_q   <= '0;
      base_q  <= '0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(ERASE_CYC - 1)) busy_q <= 1'b0;
    end else if (bus_wr) begin
      case (bus_addr)
        REG_CTRL: begin
          pwe_q <= bus_wdata[0];
          arm_q <= bus_wdata[1];
        end
        REG_PAGE: begin
          page_q  <= bus_wdata[PAGE_W:1];
          pgset_q <= 1'b1;
        end
        REG_KEY: begin
          arm_q   <= 1'b0;
          pgset_q <= 1'b0;
          if (bus_wdata == KEY_MASS && arm_q && dbg_en) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            base_q <= '0;
            len_q  <= CW'(DEPTH);
          end else if (bus_wdata == KEY_PAGE && pgset_q) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            base_q <= {page_q, {PB_W{1'b0}}};
            len_q  <= CW'(PAGE_BYTES);
          end
        end
        default: ;
      endcase
    end
  end

  assign er_we   = busy_q && (cnt_q < len_q);
  assign er_addr = base_q + cnt_q[FA_W-1:0];
  assign busy_o  = busy_q;
  assign pwe_o   = pwe_q;
  assign arm_o   = arm_q;

  // R5: every accepted key write leaves the mass arm cleared
  a_r5_key_clears_arm: assert property (@(posedge clk) disable iff (rst)
    key_wr |=> !arm_q);
  // R3: mass key with debug disabled never starts an erase
  a_r3_mass_needs_dbg: assert property (@(posedge clk) disable iff (rst)
    (key_wr && bus_wdata == KEY_MASS && !dbg_en) |=> !busy_q);
  // R4: page key after a page setup starts an erase
  a_r4_page_starts: assert property (@(posedge clk) disable iff (rst)
    (key_wr && bus_wdata == KEY_PAGE && pgset_q) |=> busy_q);
  // R9: page register frozen while busy
  a_r9_page_frozen: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> $stable(page_q));
  // R9: program enable frozen while busy
  a_r9_pwe_frozen: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> $stable(pwe_q));
endmodule

// File: rtl/fsq_flash.sv
module fsq_flash
  import fsq_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int FA_W = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            er_we,
  input  logic [FA_W-1:0] er_addr,
  input  logic            pg_we,
  input  logic [FA_W-1:0] pg_addr,
  input  logic [7:0]      pg_data,
  input  logic [FA_W-1:0] rd_addr,
  output logic [7:0]      rd_q
);
  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = ERASED;
  end

  always_ff @(posedge clk) begin
    if (er_we)      mem[er_addr] <= ERASED;
    else if (pg_we) mem[pg_addr] <= mem[pg_addr] & pg_data;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= mem[rd_addr];
  end

  // R9: a program store never coincides with an erase write
  a_r9_no_prog_in_erase: assert property (@(posedge clk) disable iff (rst)
    !(er_we && pg_we));
endmodule

// File: rtl/fsq_ram.sv
module fsq_ram #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rq
);
  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rq <= '0;
    else     rq <= mem[raddr];
  end
endmodule

// File: rtl/flash_seq_top.sv
module flash_seq_top #(
  parameter int NUM_PAGES  = 8,
  parameter int PAGE_BYTES = 16,
  parameter int RAM_BYTES  = 64,
  parameter int ERASE_CYC  = 160,
  localparam int DEPTH = NUM_PAGES * PAGE_BYTES,
  localparam int FA_W  = $clog2(DEPTH),
  localparam int RA_W  = $clog2(RAM_BYTES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dbg_en,
  input  logic            bus_wr,
  input  logic [1:0]      bus_addr,
  input  logic [7:0]      bus_wdata,
  input  logic            store_wr,
  input  logic [FA_W-1:0] store_addr,
  input  logic [7:0]      store_wdata,
  input  logic            rd_src,
  input  logic [FA_W-1:0] rd_addr,
  output logic [7:0]      rd_data,
  output logic            busy,
  output logic            prog_en,
  output logic            mass_arm
);
  logic            er_we, pg_we, ram_we, src_q;
  logic [FA_W-1:0] er_addr;
  logic [7:0]      fl_q, ram_q;

  fsq_cmd #(
    .NUM_PAGES(NUM_PAGES), .PAGE_BYTES(PAGE_BYTES), .ERASE_CYC(ERASE_CYC)
  ) u_cmd (
    .clk(clk), .rst(rst), .dbg_en(dbg_en),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .busy_o(busy), .pwe_o(prog_en), .arm_o(mass_arm),
    .er_we(er_we), .er_addr(er_addr)
  );

  assign pg_we  = store_wr && prog_en && !busy;
  assign ram_we = store_wr && !prog_en;

  fsq_flash #(.DEPTH(DEPTH)) u_flash (
    .clk(clk), .rst(rst),
    .er_we(er_we), .er_addr(er_addr),
    .pg_we(pg_we), .pg_addr(store_addr), .pg_data(store_wdata),
    .rd_addr(rd_addr), .rd_q(fl_q)
  );

  fsq_ram #(.DEPTH(RAM_BYTES)) u_ram (
    .clk(clk), .rst(rst),
    .we(ram_we), .waddr(store_addr[RA_W-1:0]), .wdata(store_wdata),
    .raddr(rd_addr[RA_W-1:0]), .rq(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) src_q <= 1'b0;
    else     src_q <= rd_src;
  end

  assign rd_data = src_q ? ram_q : fl_q;

  // R7: a RAM-bound store never programs flash
  a_r7_store_split: assert property (@(posedge clk) disable iff (rst)
    !(pg_we && ram_we));
endmodule

// File: tb/sim_flash_seq_top.sv
module sim_flash_seq_top;
  localparam int NP = 8, PB = 16, RB = 64, EC = 160;
  localparam int DEPTH = NP * PB;

  logic       clk = 1'b0, rst = 1'b1, dbg_en = 1'b0;
  logic       bus_wr = 1'b0, store_wr = 1'b0, rd_src = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, store_wdata = '0;
  logic [6:0] store_addr = '0, rd_addr = '0;
  logic [7:0] rd_data;
  logic       busy, prog_en, mass_arm;

  int n_chk = 0, n_err = 0, cyc = 0;

  flash_seq_top #(.NUM_PAGES(NP), .PAGE_BYTES(PB), .RAM_BYTES(RB), .ERASE_CYC(EC)) u0 (
    .clk(clk), .rst(rst), .dbg_en(dbg_en),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .store_wr(store_wr), .store_addr(store_addr), .store_wdata(store_wdata),
    .rd_src(rd_src), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .prog_en(prog_en), .mass_arm(mass_arm)
  );

  always #10 clk = ~clk;

  // behavioural reference model
  logic [7:0] fl [DEPTH];
  logic [7:0] ram [RB];
  logic [7:0] m_rd;
  logic       m_busy, m_pwe, m_arm, m_pgset;
  int         m_page, m_cnt, m_len, m_base;

  initial begin
    for (int i = 0; i < DEPTH; i++) fl[i] = 8'hFF;
    for (int i = 0; i < RB; i++) ram[i] = 8'h00;
  end

  always @(posedge clk) begin
    logic was_busy, old_pwe;
    if (rst) begin
      m_rd = 0; m_busy = 0; m_pwe = 0; m_arm = 0; m_pgset = 0;
      m_page = 0; m_cnt = 0; m_len = 0; m_base = 0;
    end else begin
      m_rd = rd_src ? ram[int'(rd_addr) % RB] : fl[rd_addr];
      was_busy = m_busy;
      old_pwe  = m_pwe;
      if (was_busy) begin
        if (m_cnt < m_len) fl[m_base + m_cnt] = 8'hFF;
        if (m_cnt == EC - 1) m_busy = 0;
        m_cnt++;
      end else if (bus_wr) begin
        if (bus_addr == 2'd0) begin
          m_pwe = bus_wdata[0]; m_arm = bus_wdata[1];
        end else if (bus_addr == 2'd1) begin
          m_page = (int'(bus_wdata) >> 1) % NP; m_pgset = 1;
        end else if (bus_addr == 2'd2) begin
          if (bus_wdata == 8'hAA && m_arm && dbg_en) begin
            m_busy = 1; m_cnt = 0; m_base = 0; m_len = DEPTH;
          end else if (bus_wdata == 8'h55 && m_pgset) begin
            m_busy = 1; m_cnt = 0; m_base = m_page * PB; m_len = PB;
          end
          m_arm = 0; m_pgset = 0;
        end
      end
      if (store_wr) begin
        if (!old_pwe) ram[int'(store_addr) % RB] = store_wdata;
        else if (!was_busy) fl[store_addr] = fl[store_addr] & store_wdata;
      end
    end
  end

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check({7'd0, busy},     {7'd0, m_busy}, "R8 busy vs model");
      check({7'd0, mass_arm}, {7'd0, m_arm},  "R5 mass_arm vs model");
      check({7'd0, prog_en},  {7'd0, m_pwe},  "R9 prog_en vs model");
      check(rd_data, m_rd, "R7 rd_data vs model");
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic store(input logic [6:0] a, input logic [7:0] d);
    store_wr = 1'b1; store_addr = a; store_wdata = d;
    @(negedge clk);
    store_wr = 1'b0;
  endtask

  task automatic read_expect(input logic s, input logic [6:0] a,
                             input logic [7:0] exp, input string tag);
    rd_src = s; rd_addr = a;
    @(negedge clk);
    check(rd_data, exp, tag);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check({7'd0, busy}, 8'd0, "R1 busy after reset");
    check({7'd0, prog_en}, 8'd0, "R1 prog_en after reset");
    check({7'd0, mass_arm}, 8'd0, "R1 mass_arm after reset");
    read_expect(1'b0, 7'd0, 8'hFF, "R1 erased flash byte");
    read_expect(1'b0, 7'd127, 8'hFF, "R1 erased flash last byte");

    // R6 programming ANDs
    bus_write(2'd0, 8'h01);
    store(7'd5, 8'h3C);
    read_expect(1'b0, 7'd5, 8'h3C, "R6 first program");
    store(7'd5, 8'hF0);
    read_expect(1'b0, 7'd5, 8'h30, "R6 program keeps AND");

    // R7 RAM path
    bus_write(2'd0, 8'h00);
    store(7'd5, 8'h12);
    store(7'd70, 8'h9A);
    read_expect(1'b0, 7'd5, 8'h30, "R7 flash untouched by RAM store");
    read_expect(1'b1, 7'd5, 8'h12, "R7 RAM byte");
    read_expect(1'b1, 7'd6, 8'h9A, "R7 RAM uses low address bits");

    // R4 page erase of page 2 with junk high bit
    bus_write(2'd0, 8'h01);
    store(7'd31, 8'h00); store(7'd32, 8'h00);
    store(7'd47, 8'h00); store(7'd48, 8'h00);
    bus_write(2'd1, 8'b1000_0101);
    bus_write(2'd2, 8'h55);
    check({7'd0, busy}, 8'd1, "R8 busy rises after key");
    // R9 writes during busy
    bus_write(2'd0, 8'h02);
    store(7'd60, 8'h00);
    bus_write(2'd1, 8'h0E);
    n = 3;
    while (busy) begin n++; @(negedge clk); end
    check(8'(n), 8'(EC), "R8 busy length");
    check({7'd0, prog_en}, 8'd1, "R9 control write ignored (prog_en)");
    check({7'd0, mass_arm}, 8'd0, "R9 control write ignored (arm)");
    read_expect(1'b0, 7'd60, 8'hFF, "R9 program ignored while busy");
    read_expect(1'b0, 7'd32, 8'hFF, "R4 page first byte erased");
    read_expect(1'b0, 7'd47, 8'hFF, "R4 page last byte erased");
    read_expect(1'b0, 7'd31, 8'h00, "R4 byte below page kept");
    read_expect(1'b0, 7'd48, 8'h00, "R4 byte above page kept");
    bus_write(2'd2, 8'h55);
    check({7'd0, busy}, 8'd0, "R9 page write during busy left no setup");

    // R5 wrong key and key without setup
    bus_write(2'd1, 8'h06);
    bus_write(2'd2, 8'h33);
    check({7'd0, busy}, 8'd0, "R5 wrong key no erase");
    bus_write(2'd2, 8'h55);
    check({7'd0, busy}, 8'd0, "R5 key without setup");
    read_expect(1'b0, 7'd48, 8'h00, "R5 page 3 untouched");
    bus_write(2'd0, 8'h03);
    check({7'd0, mass_arm}, 8'd1, "R5 arm set");
    bus_write(2'd2, 8'h12);
    check({7'd0, mass_arm}, 8'd0, "R5 wrong key clears arm");

    // R3 mass key without debug enable
    dbg_en = 1'b0;
    bus_write(2'd0, 8'h03);
    bus_write(2'd2, 8'hAA);
    check({7'd0, busy}, 8'd0, "R3 no erase without dbg_en");
    check({7'd0, mass_arm}, 8'd0, "R3 arm cleared");
    read_expect(1'b0, 7'd5, 8'h30, "R3 flash unchanged");

    // R2 mass erase
    dbg_en = 1'b1;
    bus_write(2'd0, 8'h03);
    bus_write(2'd2, 8'hAA);
    check({7'd0, busy}, 8'd1, "R2 mass erase starts");
    wait_idle();
    for (int a = 0; a < DEPTH; a++)
      read_expect(1'b0, 7'(a), 8'hFF, "R2 mass erased byte");
    read_expect(1'b1, 7'd5, 8'h12, "R2 RAM kept after mass erase");

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule